// File: doc/BRIEF.md
# Prescaled Trace Timestamp Counter

This block keeps the running timestamp for a trace encoder. A free-running
input tick is passed through a power-of-four prescaler, and every prescaled
tick advances a wide counter by one. A small control word chooses the
timestamp source, the prescale ratio, whether counting runs, and whether the
encoder should place a timestamp into each trace message. A clear request
zeroes the count.

The counter, the prescaler and the clear request respond only when one of the
two internal sources is selected. With no source or the external source
selected, the count is frozen and ticks and clear requests are ignored. The
flag that tells the encoder to attach timestamps comes straight from its
control bit, whatever the source and counting state.

Top module: `ts_stamp_top`

## Requirements
- R1: After reset the timestamp output, the control readback and the attach flag are all 0, and the prescale field reads 0, which means divide by 1.
- R2: Control word layout: bit 0 run, bit 1 clear request (write only, reads 0), bits 5:4 source mode, bits 9:8 prescale, bit 15 attach. All other bits, including bits 7 and 14:10, read 0 whatever was written. The cycle after a write, the readback shows the new field values.
- R3: With an internal mode selected, run set and prescale 0, every input tick raises the timestamp by 1 on the following cycle.
- R4: With prescale value p (1, 2 or 3), the timestamp advances once per 4^p ticks (4, 16 or 64). The first advance after the divider restarts comes on the 4^p-th tick.
- R5: The attach output equals the last written bit 15, in every mode and counting state.
- R6: Mode values 2 and 3 select the internal source. With mode 0 or 1, ticks do not move the timestamp or the divider, and clear requests are ignored.
- R7: With run at 0, ticks are ignored and both the timestamp and the divider keep their values. Counting resumes from where it stopped.
- R8: A write with bit 1 set and an internal mode in the written word sets the timestamp and the divider to 0 on the next cycle. A tick in that same cycle is dropped.
- R9: A write that changes the prescale value while the written mode is internal restarts the divider at 0 and drops a tick in that cycle. Rewriting the same value leaves the divider alone.
- R10: The timestamp wraps from its all-ones value to 0 and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Timestamp input tick, one pulse per clock at most |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word write data |
| ctl_rdata_o | output | 32 | Control word readback |
| ts_value_o | output | TS_W | Current timestamp |
| ts_attach_o | output | 1 | Encoder should attach a timestamp to each message |

## Verification
The prescaler's divider count never appears at the ports directly. A wrong
divider value shows up as a timestamp step that comes one or more ticks early
or late. The bench therefore places each check on the exact tick where an
advance is due, and one tick before it. A stale divider left after a clear,
a prescale change or a pause in run shows at the first advance afterwards,
within at most 64 ticks. A wrong mode or run gate shows as a count that moves
when it should hold, from the first tick on.

// File: rtl/ts_stamp_pkg.sv
package ts_stamp_pkg;

  localparam int CTL_W   = 32;
  localparam int PS_W    = 2;
  localparam int DIV_W   = 2 * ((1 << PS_W) - 1);

  localparam int B_RUN   = 0;
  localparam int B_CLR   = 1;
  localparam int B_MODE  = 4;
  localparam int B_PS    = 8;
  localparam int B_ATT   = 15;

  localparam logic [CTL_W-1:0] KEEP_MASK = 32'h0000_8331;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_SYS  = 2'd2,
    SRC_CORE = 2'd3
  } ts_src_e;

  typedef struct packed {
    logic            attach;
    logic [PS_W-1:0] ps;
    ts_src_e         mode;
    logic            run;
  } ts_ctl_t;

  function automatic logic src_internal(input ts_src_e m);
    return (m == SRC_SYS) || (m == SRC_CORE);
  endfunction

  function automatic logic [DIV_W-1:0] div_last(input logic [PS_W-1:0] ps);
    logic [DIV_W-1:0] v;
    v = '0;
    for (int i = 0; i < (1 << PS_W) - 1; i++) begin
      if (i < int'(ps)) v = {v[DIV_W-3:0], 2'b11};
    end
    return v;
  endfunction

endpackage

// File: rtl/ts_rst_sync.sv
module ts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ts_ctl_reg.sv
module ts_ctl_reg
  import ts_stamp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output ts_ctl_t          ctl,
  output logic             clr_req,
  output logic             ps_restart,
  output logic [CTL_W-1:0] rdata
);
  ts_ctl_t ctl_q, ctl_d;
  ts_src_e new_mode;
  logic    new_int;

  always_comb begin
    new_mode      = ts_src_e'(wdata[B_MODE +: 2]);
    new_int       = src_internal(new_mode);
    ctl_d         = ctl_q;
    ctl_d.run     = wdata[B_RUN];
    ctl_d.mode    = new_mode;
    ctl_d.ps      = wdata[B_PS +: PS_W];
    ctl_d.attach  = wdata[B_ATT];
    clr_req       = we && wdata[B_CLR] && new_int;
    ps_restart    = we && new_int && (wdata[B_PS +: PS_W] != ctl_q.ps);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (we) begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    rdata                  = '0;
    rdata[B_RUN]           = ctl_q.run;
    rdata[B_MODE +: 2]     = ctl_q.mode;
    rdata[B_PS +: PS_W]    = ctl_q.ps;
    rdata[B_ATT]           = ctl_q.attach;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/ts_prescaler.sv
module ts_prescaler
  import ts_stamp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            cnt_en,
  input  logic [PS_W-1:0] ps,
  input  logic            restart,
  output logic            step
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] last;
  logic             div_en;

  always_comb begin
    last   = div_last(ps);
    div_d  = div_q;
    step   = 1'b0;
    div_en = 1'b0;
    if (restart) begin
      div_d  = '0;
      div_en = 1'b1;
    end else if (tick && cnt_en) begin
      div_en = 1'b1;
      if (div_q >= last) begin
        div_d = '0;
        step  = 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  output logic [TS_W-1:0] value
);
  logic [TS_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = clr || step;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign value = cnt_q;
endmodule

// File: rtl/ts_stamp_top.sv
module ts_stamp_top
  import ts_stamp_pkg::*;
#(
  parameter int TS_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_rdata_o,
  output logic [TS_W-1:0]  ts_value_o,
  output logic             ts_attach_o
);
  logic    rst_sync_n;
  ts_ctl_t ctl;
  logic    clr_req;
  logic    ps_restart;
  logic    cnt_en;
  logic    step;

  ts_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  ts_ctl_reg u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .we         (ctl_we_i),
    .wdata      (ctl_wdata_i),
    .ctl        (ctl),
    .clr_req    (clr_req),
    .ps_restart (ps_restart),
    .rdata      (ctl_rdata_o)
  );

  assign cnt_en = ctl.run && src_internal(ctl.mode);

  ts_prescaler u_psc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick_i),
    .cnt_en  (cnt_en),
    .ps      (ctl.ps),
    .restart (clr_req || ps_restart),
    .step    (step)
  );

  ts_counter #(.TS_W(TS_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (clr_req),
    .step  (step),
    .value (ts_value_o)
  );

  assign ts_attach_o = ctl.attach;
endmodule

// File: rtl/ts_stamp_chk.sv
module ts_stamp_chk
  import ts_stamp_pkg::*;
#(
  parameter int TS_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             ctl_we_i,
  input logic [CTL_W-1:0] ctl_wdata_i,
  input logic [CTL_W-1:0] ctl_rdata_o,
  input logic [TS_W-1:0]  ts_value_o,
  input logic             ts_attach_o
);
  logic cur_int, wr_clr;
  assign cur_int = ctl_rdata_o[B_MODE + 1];
  assign wr_clr  = ctl_we_i && ctl_wdata_i[B_CLR] && ctl_wdata_i[B_MODE + 1];

  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_i |=> ctl_rdata_o == ($past(ctl_wdata_i) & KEEP_MASK));

  p_attach_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_i |=> ts_attach_o == $past(ctl_wdata_i[B_ATT]));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ts_value_o == '0);

  p_hold_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_int && !wr_clr) |=> $stable(ts_value_o));

  p_hold_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rdata_o[B_RUN] && !wr_clr) |=> $stable(ts_value_o));

  p_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_clr) |=> $stable(ts_value_o));

  p_step_ps0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ctl_we_i && cur_int && ctl_rdata_o[B_RUN]
     && ctl_rdata_o[B_PS +: PS_W] == '0)
    |=> ts_value_o == TS_W'($past(ts_value_o) + 1'b1));

  p_single_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> (ts_value_o == $past(ts_value_o)
                 || ts_value_o == TS_W'($past(ts_value_o) + 1'b1)));
endmodule

bind ts_stamp_top ts_stamp_chk #(.TS_W(TS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tick_i      (tick_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .ctl_rdata_o (ctl_rdata_o),
  .ts_value_o  (ts_value_o),
  .ts_attach_o (ts_attach_o)
);

// File: tb/ts_stamp_top_test.sv
`timescale 1ns/1ps
module ts_stamp_top_test;
  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        ctl_we_i;
  logic [31:0] ctl_wdata_i;
  logic [31:0] rdata, rdata_n;
  logic [63:0] ts;
  logic [3:0]  ts_n;
  logic        att, att_n;

  int n_chk = 0;
  int n_bad = 0;

  ts_stamp_top uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ctl_we_i(ctl_we_i),
    .ctl_wdata_i(ctl_wdata_i), .ctl_rdata_o(rdata), .ts_value_o(ts),
    .ts_attach_o(att)
  );

  ts_stamp_top #(.TS_W(4)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ctl_we_i(ctl_we_i),
    .ctl_wdata_i(ctl_wdata_i), .ctl_rdata_o(rdata_n), .ts_value_o(ts_n),
    .ts_attach_o(att_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] cw(input bit run, input bit clr,
                                     input int mode, input int ps, input bit at);
    logic [31:0] w;
    w = '0;
    w[0]   = run;
    w[1]   = clr;
    w[5:4] = 2'(mode);
    w[9:8] = 2'(ps);
    w[15]  = at;
    return w;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input bit with_tick);
    ctl_we_i    = 1'b1;
    ctl_wdata_i = d;
    tick_i      = with_tick;
    @(negedge clk);
    ctl_we_i = 1'b0;
    tick_i   = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ts", ts, 0);
    chk("R1 rdata", {32'b0, rdata}, 0);
    chk("R1 attach", {63'b0, att}, 0);
  endtask

  task automatic t_readback;
    wr(32'hFFFF_FFFF, 1'b0);
    chk("R2 readback all-ones", {32'b0, rdata}, 64'h8331);
    chk("R5 attach set", {63'b0, att}, 1);
    wr(cw(0, 0, 1, 2, 1), 1'b0);
    chk("R5 attach in ext mode", {63'b0, att}, 1);
    wr(32'h0000_7CCC, 1'b0);
    chk("R2 reserved only", {32'b0, rdata}, 0);
    chk("R5 attach clear", {63'b0, att}, 0);
  endtask

  task automatic t_ps0;
    wr(cw(1, 1, 2, 0, 0), 1'b0);
    chk("R8 clear", ts, 0);
    ticks(5);
    chk("R3 five ticks", ts, 5);
    repeat (3) @(negedge clk);
    chk("R3 idle holds", ts, 5);
  endtask

  task automatic t_psn;
    for (int p = 1; p <= 3; p++) begin
      int per;
      per = 1 << (2 * p);
      wr(cw(1, 1, 3, p, 0), 1'b0);
      ticks(per - 1);
      chk("R4 one before period", ts, 0);
      ticks(1);
      chk("R4 first period", ts, 1);
      ticks(per);
      chk("R4 second period", ts, 2);
    end
  endtask

  task automatic t_mode;
    wr(cw(1, 1, 3, 0, 0), 1'b0);
    ticks(3);
    chk("R6 mode3 counts", ts, 3);
    wr(cw(1, 0, 1, 0, 0), 1'b0);
    ticks(4);
    chk("R6 mode1 holds", ts, 3);
    wr(cw(1, 1, 1, 0, 0), 1'b0);
    chk("R6 mode1 clear ignored", ts, 3);
    wr(cw(1, 1, 0, 0, 0), 1'b0);
    ticks(2);
    chk("R6 mode0 holds and ignores clear", ts, 3);
    wr(cw(1, 0, 2, 0, 0), 1'b0);
    ticks(1);
    chk("R6 mode2 resumes", ts, 4);
  endtask

  task automatic t_run;
    wr(cw(1, 1, 2, 1, 0), 1'b0);
    ticks(2);
    wr(cw(0, 0, 2, 1, 0), 1'b0);
    ticks(10);
    chk("R7 run off holds", ts, 0);
    wr(cw(1, 0, 2, 1, 0), 1'b0);
    ticks(1);
    chk("R7 divider kept, 3 of 4", ts, 0);
    ticks(1);
    chk("R7 divider kept, 4 of 4", ts, 1);
  endtask

  task automatic t_clear;
    wr(cw(1, 1, 2, 0, 0), 1'b0);
    ticks(6);
    chk("R8 count before clear", ts, 6);
    wr(cw(1, 1, 2, 0, 0), 1'b1);
    chk("R8 clear beats tick", ts, 0);
    ticks(1);
    chk("R8 count after clear", ts, 1);
    wr(cw(1, 1, 2, 1, 0), 1'b0);
    ticks(3);
    wr(cw(1, 1, 2, 1, 0), 1'b0);
    ticks(3);
    chk("R8 divider cleared", ts, 0);
    ticks(1);
    chk("R8 full period after clear", ts, 1);
  endtask

  task automatic t_pschg;
    wr(cw(1, 1, 2, 2, 0), 1'b0);
    ticks(5);
    wr(cw(1, 0, 2, 1, 0), 1'b1);
    ticks(3);
    chk("R9 restart, 3 of 4", ts, 0);
    ticks(1);
    chk("R9 restart, 4 of 4", ts, 1);
    ticks(2);
    wr(cw(1, 0, 2, 1, 0), 1'b0);
    ticks(2);
    chk("R9 same value keeps divider", ts, 2);
  endtask

  task automatic t_wrap;
    wr(cw(1, 1, 2, 0, 0), 1'b0);
    ticks(15);
    chk("R10 narrow at max", {60'b0, ts_n}, 15);
    ticks(1);
    chk("R10 narrow wraps to 0", {60'b0, ts_n}, 0);
    chk("R10 wide keeps going", ts, 16);
  endtask

  initial begin
    rst_n       = 1'b0;
    tick_i      = 1'b0;
    ctl_we_i    = 1'b0;
    ctl_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_readback;
    t_ps0;
    t_psn;
    t_mode;
    t_run;
    t_clear;
    t_pschg;
    t_wrap;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule